// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

The controller arbitrates among ten interrupt vectors on behalf of a processor core. Each vector is fed by a pending line, which the surrounding peripherals already reduce to one bit per vector, and each carries a software-chosen priority code. The controller picks one winning vector and raises a request line. The winner is decided first by level and then, among equal levels, by the lowest address. It also presents that vector's address. The core answers with a one-cycle acknowledge when it enters the handler, and a one-cycle return pulse when it leaves.

Three levels exist: low, high and highest. Only the first two vectors may be placed at the highest level. The controller records which levels are in service, so that nested handling works. While a handler runs, requests at its own level or below stay pending and are not issued, and requests at a strictly higher level can still preempt it. A master enable silences the request line without disturbing the record of levels in service.

Top module: `intc_vectored`

## Requirements
- R1: After reset no level is in service. With no pending vector, `irq_o` is 0 and `vec_addr_o` is 0. Whenever `irq_o` is 0, `vec_addr_o` is 0.
- R2: When vector i (0..9) is issued, `vec_addr_o` equals 3 + 8*i, giving 0x03 for vector 0 and 0x4B for vector 9.
- R3: Among pending vectors, one at a higher level wins over one at a lower level. The order is highest, then high, then low.
- R4: Among pending vectors at the same level, the lowest index wins.
- R5: The priority code of vector i is `prio_i[2i+1:2i]`: 00 means low, 01 means high, and 1x means highest. Code 1x gives the highest level only for vectors 0 and 1. For vectors 2..9, code 1x gives high.
- R6: `irq_o` is 1 only when the winning pending vector has a level strictly above the highest level currently in service. Equal and lower levels stay blocked.
- R7: An `ack_i` pulse while `irq_o` is 1 marks the issued vector's level as in service. An `ack_i` while `irq_o` is 0 has no effect.
- R8: A `reti_i` pulse takes the highest in-service level out of service and leaves the lower ones in place. A `reti_i` with nothing in service has no effect.
- R9: With `en_i` at 0, `irq_o` is 0 whatever is pending. The in-service record is unchanged by this.
- R10: When `ack_i` (with `irq_o` at 1) and `reti_i` arrive in the same cycle, the pop is applied first and then the push. The net result is that the issued level is in service and the previous top level is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable for the request line |
| req_i | input | 10 | Pending request, one bit per vector |
| prio_i | input | 20 | Two-bit priority code per vector |
| ack_i | input | 1 | Core has entered the issued handler (one-cycle pulse) |
| reti_i | input | 1 | Core has returned from a handler (one-cycle pulse) |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 8 | Address of the issued vector, 0 when idle |

## Verification
Several properties are checked on every cycle by the assertions:
- The request line stays low while disabled or while the highest level is in service.
- Any issued address has the 3-plus-multiple-of-8 form.
- An accepted acknowledge adds exactly one in-service level.
- A return removes exactly one in-service level.
- Both together leave the count of in-service levels unchanged.

Which vector wins and which level was removed can only be shown by the bench's scenarios. These include the level-versus-index ordering, the demotion of code 1x on vectors 2 to 9, and the blocking of equal-level requests during nested service. They also cover the pop-then-push order when both pulses coincide.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_TOP  = 2'd3
    } lvl_e;

    // Highest level present in a one-bit-per-level service record
    function automatic lvl_e top_level(input logic [2:0] act);
        if (act[2])      return LV_TOP;
        else if (act[1]) return LV_HIGH;
        else if (act[0]) return LV_LOW;
        else             return LV_NONE;
    endfunction

    // Record with its highest set bit cleared
    function automatic logic [2:0] drop_top(input logic [2:0] act);
        if (act[2])      return {1'b0, act[1:0]};
        else if (act[1]) return {2'b00, act[0]};
        else             return 3'b000;
    endfunction

endpackage

// File: rtl/intc_level_decode.sv
module intc_level_decode
    import intc_pkg::*;
#(
    parameter int N_VEC = 10,
    parameter int N_TOP = 2
) (
    input  logic [2*N_VEC-1:0] prio_i,
    output logic [2*N_VEC-1:0] lvl_o
);

    for (genvar i = 0; i < N_VEC; i++) begin : g_vec
        logic [1:0] code;
        lvl_e       lvl;
        assign code = prio_i[2*i +: 2];
        if (i < N_TOP) begin : g_top_ok
            // R5: code 1x reaches the highest level on the first vectors only
            always_comb begin
                if (code[1])      lvl = LV_TOP;
                else if (code[0]) lvl = LV_HIGH;
                else              lvl = LV_LOW;
            end
        end else begin : g_top_no
            always_comb lvl = (code != 2'b00) ? LV_HIGH : LV_LOW;
        end
        assign lvl_o[2*i +: 2] = lvl;
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_VEC = 10,
    localparam int IDX_W = $clog2(N_VEC)
) (
    input  logic [N_VEC-1:0]   req_i,
    input  logic [2*N_VEC-1:0] lvl_i,
    output logic [IDX_W-1:0]   win_idx_o,
    output lvl_e               win_lvl_o
);

    // R3/R4: strict compare while scanning upward keeps the lowest index on ties
    always_comb begin
        win_idx_o = '0;
        win_lvl_o = LV_NONE;
        for (int i = 0; i < N_VEC; i++) begin
            if (req_i[i] && (lvl_i[2*i +: 2] > win_lvl_o)) begin
                win_lvl_o = lvl_e'(lvl_i[2*i +: 2]);
                win_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_level_stack.sv
module intc_level_stack
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  lvl_e       push_lvl_i,
    input  logic       pop_i,
    output logic [2:0] act_o,
    output lvl_e       cur_lvl_o
);

    typedef struct packed {
        logic [2:0] act;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // R10: pop before push when both arrive together
        if (pop_i) begin
            st_d.act = drop_top(st_q.act);
        end
        if (push_i && (push_lvl_i != LV_NONE)) begin
            st_d.act[push_lvl_i - 2'd1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o     = st_q.act;
    assign cur_lvl_o = top_level(st_q.act);

endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
    import intc_pkg::*;
#(
    parameter int N_VEC      = 10,
    parameter int N_TOP      = 2,
    parameter int ADDR_W     = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    localparam int IDX_W     = $clog2(N_VEC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [N_VEC-1:0]    req_i,
    input  logic [2*N_VEC-1:0]  prio_i,
    input  logic                ack_i,
    input  logic                reti_i,
    output logic                irq_o,
    output logic [ADDR_W-1:0]   vec_addr_o
);

    logic [2*N_VEC-1:0] lvl;
    logic [IDX_W-1:0]   win_idx;
    lvl_e               win_lvl;
    lvl_e               cur_lvl;
    logic [2:0]         act_q;
    logic               irq;

    intc_level_decode #(.N_VEC(N_VEC), .N_TOP(N_TOP)) i_decode (
        .prio_i (prio_i),
        .lvl_o  (lvl)
    );

    intc_arbiter #(.N_VEC(N_VEC)) i_arb (
        .req_i     (req_i),
        .lvl_i     (lvl),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    // R6/R9: issue only above the in-service level and only when enabled
    assign irq = en_i && (win_lvl > cur_lvl);

    intc_level_stack i_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack_i && irq),
        .push_lvl_i (win_lvl),
        .pop_i      (reti_i),
        .act_o      (act_q),
        .cur_lvl_o  (cur_lvl)
    );

    assign irq_o      = irq;
    // R2: vector address from the winning index
    assign vec_addr_o = irq ? ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx)) : '0;

endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              ack_i,
    input logic              reti_i,
    input logic              irq_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic [2:0]        act_q
);

    a_r1_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_addr_o == '0));

    a_r2_addr_form: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_addr_o[2:0] == 3'b011));

    a_r6_top_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        act_q[2] |-> !irq_o);

    a_r7_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !reti_i) |=> ($countones(act_q) == $countones($past(act_q)) + 1));

    a_r8_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i && (act_q != 3'b000)) |=> ($countones(act_q) + 1 == $countones($past(act_q))));

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !irq_o);

    a_r10_both_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && reti_i && (act_q != 3'b000)) |=> ($countones(act_q) == $countones($past(act_q))));

endmodule

bind intc_vectored intc_vectored_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .irq_o      (irq_o),
    .vec_addr_o (vec_addr_o),
    .act_q      (act_q)
);

// File: tb/test_intc_vectored.sv
module test_intc_vectored;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_i = 1'b0;
    logic [NV-1:0]   req_i = '0;
    logic [2*NV-1:0] prio_i = '0;
    logic            ack_i = 1'b0;
    logic            reti_i = 1'b0;
    logic            irq_o;
    logic [7:0]      vec_addr_o;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    typedef struct {
        logic       irq;
        logic [7:0] addr;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_vectored i_intc_vectored (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .req_i      (req_i),
        .prio_i     (prio_i),
        .ack_i      (ack_i),
        .reti_i     (reti_i),
        .irq_o      (irq_o),
        .vec_addr_o (vec_addr_o)
    );

    function automatic logic [2*NV-1:0] pc(input int v, input logic [1:0] code);
        logic [2*NV-1:0] r = '0;
        r[2*v +: 2] = code;
        return r;
    endfunction

    function automatic logic [NV-1:0] rq(input int v);
        logic [NV-1:0] r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

    // Driver: applies one cycle of stimulus and queues what the outputs must show
    task automatic step(input logic [NV-1:0] rv, input logic [2*NV-1:0] pv,
                        input logic en, input logic ack, input logic reti,
                        input logic exp_irq, input int exp_idx, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        req_i = rv; prio_i = pv; en_i = en; ack_i = ack; reti_i = reti;
        e.irq  = exp_irq;
        e.addr = exp_irq ? 8'(3 + 8 * exp_idx) : 8'h00;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: compares away from the rising edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (irq_o !== e.irq || vec_addr_o !== e.addr) begin
                bad++;
                $display("FAIL %s: irq=%0b addr=%02h expected irq=%0b addr=%02h",
                         e.tag, irq_o, vec_addr_o, e.irq, e.addr);
            end
        end
    end

    initial begin
        logic [2*NV-1:0] pn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, nothing pending
        step('0, '0, 1, 0, 0, 0, 0, "R1 reset idle");
        // R2: address mapping at both ends
        step(rq(9), '0, 1, 0, 0, 1, 9, "R2 vector 9 address");
        step(rq(0), '0, 1, 0, 0, 1, 0, "R2 vector 0 address");
        // R4: tie at low level
        step(rq(3) | rq(5), '0, 1, 0, 0, 1, 3, "R4 lowest index on tie");
        // R3: level beats index
        step(rq(3) | rq(5), pc(5, 2'b01), 1, 0, 0, 1, 5, "R3 high beats low");
        // R5: top level on vector 0 only for eligible ones
        step(rq(0) | rq(8), pc(0, 2'b10) | pc(8, 2'b01), 1, 0, 0, 1, 0, "R5 highest on vector 0");
        step(rq(4) | rq(2), pc(4, 2'b10) | pc(2, 2'b01), 1, 0, 0, 1, 2, "R5 code 1x on vector 4 is only high");
        step(rq(4) | rq(6), pc(4, 2'b11), 1, 0, 0, 1, 4, "R5 code 1x on vector 4 beats low");

        // Nesting: v5 high, v2 low, v1 highest
        pn = pc(5, 2'b01) | pc(1, 2'b10);
        step(rq(5), pn, 1, 1, 0, 1, 5, "R7 ack of high vector");
        step(rq(5), pn, 1, 0, 0, 0, 0, "R6 equal level blocked");
        step(rq(5) | rq(2), pn, 1, 0, 0, 0, 0, "R6 lower level blocked");
        step(rq(5) | rq(1), pn, 1, 0, 0, 1, 1, "R6 higher level nests");
        step(rq(5) | rq(1), pn, 1, 1, 0, 1, 1, "R7 ack of highest vector");
        step(rq(5) | rq(1) | rq(2), pn, 1, 0, 0, 0, 0, "R6 highest in service blocks all");
        step('0, pn, 1, 0, 1, 0, 0, "R8 first return");
        step(rq(5), pn, 1, 0, 0, 0, 0, "R8 pop leaves high in service");
        step('0, pn, 1, 0, 1, 0, 0, "R8 second return");
        step(rq(2), pn, 1, 0, 0, 1, 2, "R8 all levels released");
        step(rq(2), pn, 1, 0, 1, 1, 2, "R8 return with empty record");
        step(rq(2), pn, 1, 0, 0, 1, 2, "R8 empty return ignored");

        // R9 and ignored acknowledge
        step(rq(1) | rq(2), pn, 0, 0, 0, 0, 0, "R9 disabled");
        step(rq(2), pn, 0, 1, 0, 0, 0, "R7 ack while idle");
        step(rq(2), pn, 1, 0, 0, 1, 2, "R7 idle ack left nothing in service");

        // R10: pop-then-push ordering
        step(rq(2), pn, 1, 1, 0, 1, 2, "R10 setup low in service");
        step(rq(5), pn, 1, 0, 0, 1, 5, "R10 high preempts low");
        step(rq(5), pn, 1, 1, 1, 1, 5, "R10 ack and return together");
        step(rq(5), pn, 1, 0, 0, 0, 0, "R10 high now in service");
        step(rq(2), pn, 1, 0, 0, 0, 0, "R10 low still blocked");
        step('0, pn, 1, 0, 1, 0, 0, "R10 return of high");
        step(rq(2), pn, 1, 0, 0, 1, 2, "R10 low was popped first");

        step('0, '0, 1, 0, 0, 0, 0, "R1 quiet at end");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule